// File: doc/BRIEF.md
# Four-Channel Conversion Sequence Controller

This block is the digital control core of a four-channel simultaneous-sampling converter. A rising edge on the convert-start input freezes a four-bit channel-enable mask and starts a conversion sequence. A mode input chooses where the mask comes from: four hardware select pins or a software channel register. The controller then visits each enabled channel in ascending order. It spends a fixed number of conversion-clock cycles on each one and captures that channel's result into its own output register. A busy flag stays high for the whole sequence.

The analog front end sits outside the block. The channel being converted is shown on `conv_ch`, and its 14-bit result is presented on `conv_data`. A chip-select / read / write bus loads the channel register and reads results back. Each completed read moves a read pointer to the next enabled result. A first-data flag marks the first result of the sequence. The conversion clock is the block clock `clk`.

Top module: `quad_seq_ctrl`

## Requirements
- R1: After reset, `busy` is 0, `first_data` is 1, `dout_oe` is 0, the read pointer addresses channel 0, and every result register and the channel register hold 0.
- R2: When `busy` is low, a 0-to-1 change of `conv_start` sampled at a clock edge sets `busy` at that same edge, and `conv_ch` then shows the lowest enabled channel.
- R3: For a mask with N>0 enabled channels, `busy` stays high for exactly 15·N clock cycles. Channels are converted in ascending index order, 15 cycles each, and `conv_ch` names the channel in progress.
- R4: With `src_is_reg`=0 the mask is `pin_sel` (bit k set = channel k enabled). With `src_is_reg`=1 it is the channel register.
- R5: The mask is captured at the accepting edge. Changes to `pin_sel` or to the channel register during `busy` do not alter the running sequence.
- R6: A rising edge of `wr_n` while `cs_n`=0 and `rd_n`=1 loads `bus_din[3:0]` into the channel register. A `wr_n` edge while `rd_n`=0 or `cs_n`=1 leaves the register unchanged.
- R7: `dout_oe` is 1 exactly while `cs_n` and `rd_n` are both 0. At all other times `dout` is 0.
- R8: Channel k's result register takes the value of `conv_data` in the last (15th) cycle of channel k's conversion. `dout` shows the register that the read pointer addresses.
- R9: Accepting a sequence resets the read pointer to the lowest enabled channel. Each rising edge of `rd_n` with `cs_n`=0 moves it to the next higher enabled channel, wrapping to the lowest after the highest.
- R10: `first_data` is 1 exactly when the read pointer addresses the lowest enabled channel of the latched mask (channel 0 for an empty mask).
- R11: A `conv_start` rising edge while `busy` is high is ignored.
- R12: An all-zero mask makes `busy` high for exactly one clock cycle, and no result register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_start | input | 1 | Convert-start level; its rising edge begins a sequence |
| src_is_reg | input | 1 | Mask source: 0 = pins, 1 = channel register |
| pin_sel | input | 4 | Hardware channel-enable pins, bit k for channel k |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| bus_din | input | 4 | Bus write data for the channel register |
| conv_data | input | 14 | Result of the channel named by `conv_ch` |
| conv_ch | output | 2 | Channel currently being converted |
| busy | output | 1 | High for the whole conversion sequence |
| first_data | output | 1 | Read pointer addresses the first result |
| dout | output | 14 | Read data, zero when not enabled |
| dout_oe | output | 1 | Output enable for `dout` (tri-state model) |

## Verification
The assertions assume that every input is synchronous to `clk`, so each strobe edge is seen exactly once by the internal edge detectors. They also assume that `wr_n` and `rd_n` are never low together inside one intended access. The bench drives all inputs on the falling clock edge and changes only one bus strobe per cycle. It holds `conv_start` high for a single cycle. It disturbs the pins, the register and `conv_start` only in the middle of a sequence, where the latched mask and the running count must absorb the disturbance.

// File: rtl/qsc_pkg.sv
package qsc_pkg;
  localparam int QSC_CH = 4;
  localparam int QSC_IW = $clog2(QSC_CH);

  typedef logic [QSC_CH-1:0] qsc_mask_t;
  typedef logic [QSC_IW-1:0] qsc_idx_t;

  // lowest enabled channel, 0 for an empty mask
  function automatic qsc_idx_t qsc_first(qsc_mask_t m);
    qsc_idx_t r = '0;
    for (int i = QSC_CH - 1; i >= 0; i--)
      if (m[i]) r = qsc_idx_t'(i);
    return r;
  endfunction

  // is any channel above cur enabled
  function automatic logic qsc_has_after(qsc_mask_t m, qsc_idx_t cur);
    logic h = 1'b0;
    for (int i = 0; i < QSC_CH; i++)
      if (i > int'(cur) && m[i]) h = 1'b1;
    return h;
  endfunction

  // next enabled channel above cur, wrapping to the lowest
  function automatic qsc_idx_t qsc_after(qsc_mask_t m, qsc_idx_t cur);
    qsc_idx_t r = qsc_first(m);
    logic found = 1'b0;
    for (int i = 0; i < QSC_CH; i++)
      if (!found && i > int'(cur) && m[i]) begin
        r = qsc_idx_t'(i);
        found = 1'b1;
      end
    return r;
  endfunction
endpackage

// File: rtl/qsc_edge.sv
module qsc_edge #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] lvl_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lvl_q <= RST_VAL;
    else        lvl_q <= lvl;

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/qsc_seq.sv
module qsc_seq
  import qsc_pkg::*;
#(
  parameter int CONV_CYCLES = 15
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_rise,
  input  qsc_mask_t mask_in,
  output logic      busy,
  output qsc_mask_t mask_q,
  output qsc_idx_t  cur_ch,
  output logic      accept,
  output logic      store
);
  localparam int CW = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          last;

  assign last   = (cnt == LAST);
  assign accept = !busy && start_rise;
  assign store  = busy && (mask_q != '0) && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      mask_q <= '0;
      cur_ch <= '0;
      cnt    <= '0;
    end else if (!busy) begin
      if (start_rise) begin
        busy   <= 1'b1;
        mask_q <= mask_in;
        cur_ch <= qsc_first(mask_in);
        cnt    <= '0;
      end
    end else if (mask_q == '0) begin
      busy <= 1'b0;
    end else if (last) begin
      cnt <= '0;
      if (qsc_has_after(mask_q, cur_ch)) cur_ch <= qsc_after(mask_q, cur_ch);
      else                               busy   <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(cnt) < CONV_CYCLES));
  assert_cur_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mask_q != '0) |-> mask_q[cur_ch]);
  assert_ascending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && cur_ch != $past(cur_ch)) |-> (cur_ch > $past(cur_ch)));
  assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mask_q));
  assert_ignore_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_rise && mask_q != '0 && !last) |=> (cnt == $past(cnt) + 1'b1));
  assert_zero_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mask_q == '0) |=> !busy);
endmodule

// File: rtl/qsc_results.sv
module qsc_results
  import qsc_pkg::*;
#(
  parameter int DW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          store,
  input  qsc_idx_t      cur_ch,
  input  logic [DW-1:0] conv_data,
  input  logic          accept,
  input  qsc_mask_t     mask_in,
  input  qsc_mask_t     mask_q,
  input  logic          rd_adv,
  output logic [DW-1:0] rd_data,
  output logic          first_data
);
  logic [DW-1:0] res [QSC_CH];
  qsc_idx_t      ptr;

  for (genvar g = 0; g < QSC_CH; g++) begin : g_res
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                                res[g] <= '0;
      else if (store && cur_ch == qsc_idx_t'(g)) res[g] <= conv_data;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ptr <= '0;
    else if (accept) ptr <= qsc_first(mask_in);
    else if (rd_adv) ptr <= qsc_after(mask_q, ptr);

  assign rd_data    = res[ptr];
  assign first_data = (ptr == qsc_first(mask_q));

  assert_ptr_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q != '0) |-> mask_q[ptr]);
  assert_ptr_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(accept) |-> first_data);
  assert_hold_unread_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(store) && !$past(rd_adv) && !$past(accept)) |-> $stable(rd_data));
endmodule

// File: rtl/quad_seq_ctrl.sv
module quad_seq_ctrl
  import qsc_pkg::*;
#(
  parameter int DW          = 14,
  parameter int CONV_CYCLES = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_start,
  input  logic          src_is_reg,
  input  logic [3:0]    pin_sel,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [3:0]    bus_din,
  input  logic [DW-1:0] conv_data,
  output logic [1:0]    conv_ch,
  output logic          busy,
  output logic          first_data,
  output logic [DW-1:0] dout,
  output logic          dout_oe
);
  logic [2:0]    rises;
  logic          start_rise, rd_rise, wr_rise;
  logic          wr_load, rd_adv, accept, store;
  qsc_mask_t     chan_reg, mask_in, mask_q;
  qsc_idx_t      cur_ch;
  logic [DW-1:0] rd_data;

  // bit 0 start, bit 1 read strobe, bit 2 write strobe (strobes idle high)
  qsc_edge #(.W(3), .RST_VAL(3'b110)) u_edge (
    .clk (clk), .rst_n (rst_n),
    .lvl ({wr_n, rd_n, conv_start}),
    .rise(rises)
  );
  assign start_rise = rises[0];
  assign rd_rise    = rises[1];
  assign wr_rise    = rises[2];

  assign wr_load = wr_rise && !cs_n && rd_n;
  assign rd_adv  = rd_rise && !cs_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       chan_reg <= '0;
    else if (wr_load) chan_reg <= bus_din[QSC_CH-1:0];

  assign mask_in = src_is_reg ? chan_reg : pin_sel[QSC_CH-1:0];

  qsc_seq #(.CONV_CYCLES(CONV_CYCLES)) u_seq (
    .clk (clk), .rst_n (rst_n),
    .start_rise (start_rise), .mask_in (mask_in),
    .busy (busy), .mask_q (mask_q), .cur_ch (cur_ch),
    .accept (accept), .store (store)
  );

  qsc_results #(.DW(DW)) u_res (
    .clk (clk), .rst_n (rst_n),
    .store (store), .cur_ch (cur_ch), .conv_data (conv_data),
    .accept (accept), .mask_in (mask_in), .mask_q (mask_q),
    .rd_adv (rd_adv), .rd_data (rd_data), .first_data (first_data)
  );

  assign conv_ch = 2'(cur_ch);
  assign dout_oe = !cs_n && !rd_n;
  assign dout    = dout_oe ? rd_data : '0;

  assert_busy_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_rise));
  assert_reg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_rise && !cs_n && rd_n) |=> $stable(chan_reg));
endmodule

// File: tb/tb_quad_seq_ctrl.sv
module tb_quad_seq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n, conv_start, src_is_reg, cs_n, rd_n, wr_n;
  logic [3:0]  pin_sel, bus_din;
  logic [13:0] conv_data, dout;
  logic [1:0]  conv_ch;
  logic        busy, first_data, dout_oe;
  logic [11:0] run_id;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [13:0] exp_res [4];
  int exp_ptr;

  always #4 clk = ~clk;

  // front end stand-in: result encodes the run and the channel
  assign conv_data = {run_id, conv_ch};

  quad_seq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .src_is_reg(src_is_reg),
    .pin_sel(pin_sel), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .bus_din(bus_din),
    .conv_data(conv_data), .conv_ch(conv_ch), .busy(busy),
    .first_data(first_data), .dout(dout), .dout_oe(dout_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int lowest(input logic [3:0] m);
    for (int c = 0; c < 4; c++) if (m[c]) return c;
    return 0;
  endfunction

  function automatic int nth_on(input logic [3:0] m, input int k);
    int seen = 0;
    for (int c = 0; c < 4; c++)
      if (m[c]) begin
        if (seen == k) return c;
        seen++;
      end
    return 0;
  endfunction

  function automatic int step_ptr(input logic [3:0] m, input int p);
    for (int s = 1; s <= 4; s++) if (m[(p + s) % 4]) return (p + s) % 4;
    return p;
  endfunction

  task automatic bus_write(input logic [3:0] v, input bit rd_low, input bit cs_high);
    @(negedge clk); cs_n = cs_high; rd_n = !rd_low; bus_din = v;
    @(negedge clk); wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic bus_read(input logic [3:0] m, input string tag);
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    chk(dout_oe == 1'b1, {"R7 oe during read ", tag}, dout_oe, 1);
    chk(dout == exp_res[exp_ptr], {"R8/R9 read data ", tag}, dout, exp_res[exp_ptr]);
    chk(first_data == (exp_ptr == lowest(m)), {"R10 first_data ", tag},
        first_data, exp_ptr == lowest(m));
    rd_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
    chk(dout_oe == 1'b0 && dout == '0, {"R7 idle output ", tag}, dout, 0);
    exp_ptr = step_ptr(m, exp_ptr);
  endtask

  task automatic run_seq(input bit mode, input logic [3:0] m);
    int n, dur;
    run_id = run_id + 1'b1;
    if (mode) begin
      bus_write(m, 1'b0, 1'b0);
      bus_write(~m, 1'b1, 1'b0);   // R6 write with read low: ignored
      bus_write(~m, 1'b0, 1'b1);   // R6 write without chip select: ignored
      src_is_reg = 1'b1; pin_sel = ~m;
    end else begin
      bus_write(~m, 1'b0, 1'b0);   // R4 register disagrees with pins
      src_is_reg = 1'b0; pin_sel = m;
    end
    n = $countones(m);
    dur = (n == 0) ? 1 : 15 * n;
    @(negedge clk); conv_start = 1'b1;
    for (int j = 0; j <= dur; j++) begin
      @(negedge clk);
      if (j == 0) begin
        conv_start = 1'b0;
        chk(busy == 1'b1, "R2 busy on start edge", busy, 1);
      end
      if (j < dur) chk(busy == 1'b1, (n == 0) ? "R12 busy pulse" : "R3/R4 busy held", busy, 1);
      else         chk(busy == 1'b0, (n == 0) ? "R12 busy one cycle" : "R3/R5 busy length", busy, 0);
      if (n > 0 && j < dur)
        chk(int'(conv_ch) == nth_on(m, j / 15), "R3 channel order", conv_ch, nth_on(m, j / 15));
      if (dur >= 15) begin          // R5 and R11 disturbances while busy
        if (j == 2) begin conv_start = 1'b1; pin_sel = ~m; end
        if (j == 3) conv_start = 1'b0;
        if (j == 4) begin cs_n = 1'b0; bus_din = ~m; end
        if (j == 5) wr_n = 1'b0;
        if (j == 6) wr_n = 1'b1;
        if (j == 7) cs_n = 1'b1;
      end
    end
    for (int c = 0; c < 4; c++) if (m[c]) exp_res[c] = {run_id, 2'(c)};
    exp_ptr = lowest(m);
    for (int r = 0; r < ((n == 0) ? 1 : n) + 1; r++) bus_read(m, mode ? "reg" : "pin");
  endtask

  initial begin
    rst_n = 1'b0; conv_start = 1'b0; src_is_reg = 1'b0; pin_sel = '0;
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; bus_din = '0; run_id = '0;
    for (int c = 0; c < 4; c++) exp_res[c] = '0;
    exp_ptr = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
    chk(first_data == 1'b1, "R1 first_data after reset", first_data, 1);
    chk(dout_oe == 1'b0, "R1 oe after reset", dout_oe, 0);
    bus_read(4'b0000, "R1 reset");
    // register starts at 0: register-mode start gives the empty-mask pulse
    src_is_reg = 1'b1; pin_sel = 4'hF;
    @(negedge clk); conv_start = 1'b1;
    @(negedge clk); conv_start = 1'b0;
    chk(busy == 1'b1, "R1 reg empty pulse", busy, 1);
    @(negedge clk);
    chk(busy == 1'b0, "R1 reg reset value", busy, 0);
    for (int md = 0; md < 2; md++)
      for (int m = 0; m < 16; m++) run_seq(md[0], 4'(m));
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule